// File: doc/BRIEF.md
# Dual-Rail Pipeline Stage Handshake Controller

This block controls one stage of a four-phase asynchronous pipeline whose data travels as dual-rail pairs, with no separate request wire. A completion detector looks at every pair of the incoming bundle and raises a request once the whole bundle holds a valid word. It drops that request only after every pair has gone back to the empty code. The request acknowledges the upstream stage and enables the stage's logic to evaluate.

An enhanced C-element watches the request and the acknowledge from the downstream stage. As soon as the downstream stage has taken the result, it puts the stage into sleep (discharge) without waiting for the next empty token. The stage leaves sleep only when both the request and the downstream acknowledge have returned low. The upstream acknowledge is held high until that release has happened, so upstream cannot offer a new valid word too early. A pair with both wires high is illegal: it is never counted as valid, and it raises an error flag.

All C-elements are modelled as state-holding registers on the system clock. Every output therefore follows its inputs by one clock.

Top module: `dr_stage_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, cd_req, up_ack, stage_en, stage_sleep and rail_err are all 0.
- R2: A bit pair is valid when exactly one of in_t[i], in_f[i] is 1. cd_req becomes 1 one clock after a cycle in which all NBITS pairs are valid.
- R3: A bit pair is empty when both wires are 0. cd_req becomes 0 one clock after a cycle in which all pairs are empty. In any other cycle (a mix of valid, empty or illegal pairs) it keeps its value.
- R4: A pair with both wires at 1 is illegal and never counts as valid. rail_err is 1 exactly one clock after a cycle that contains at least one illegal pair, and 0 otherwise.
- R5: stage_en is 1 exactly when cd_req is 1 and stage_sleep is 0.
- R6: stage_sleep becomes 1 one clock after a cycle in which cd_req and dn_ack are both 1. A dn_ack of 1 while cd_req is 0 does not set it.
- R7: stage_sleep becomes 0 one clock after a cycle in which cd_req and dn_ack are both 0. Otherwise it holds.
- R8: up_ack becomes 1 one clock after a cycle with cd_req at 1. It becomes 0 one clock after a cycle with cd_req and stage_sleep both 0. Otherwise it holds.
- R9: After early sleep, dn_ack returning to 0 while cd_req is still 1 keeps stage_sleep at 1 and stage_en at 0. A new evaluation needs an empty token first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all C-elements |
| rst_n | input | 1 | Active-low synchronous reset |
| in_t | input | NBITS | True rail of each input bit pair |
| in_f | input | NBITS | False rail of each input bit pair |
| dn_ack | input | 1 | Acknowledge from the downstream stage |
| up_ack | output | 1 | Acknowledge to the upstream stage |
| cd_req | output | 1 | Completion detector request |
| stage_en | output | 1 | Evaluate enable for the stage logic |
| stage_sleep | output | 1 | Early discharge / sleep control |
| rail_err | output | 1 | Illegal pair seen in the previous cycle |

## Verification
The collision that matters is the arrival of the empty token and the release of the downstream acknowledge in the same cycle. If both happen together, cd_req falls and the sleep latch clears on consecutive clocks, and up_ack must fall on the clock after that. A directed case drives both edges in one cycle. Random runs vary the acknowledge delay from zero upward, so the collision also appears among other timings. Every cycle, each output is compared against a cycle model in the bench that is built from the requirements.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef struct packed {
        logic slp;   // early-sleep C* element state
        logic ack;   // upstream acknowledge state
        logic err;   // illegal pair flag
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{slp: 1'b0, ack: 1'b0, err: 1'b0};

endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode #(
    parameter int NBITS = 8
) (
    input  logic [NBITS-1:0] in_t,
    input  logic [NBITS-1:0] in_f,
    output logic [NBITS-1:0] pair_valid,
    output logic [NBITS-1:0] pair_busy,
    output logic             any_illegal
);

    logic [NBITS-1:0] pair_bad;

    for (genvar i = 0; i < NBITS; i++) begin : g_pair
        // a pair is valid only with exactly one wire high
        assign pair_valid[i] = in_t[i] ^ in_f[i];
        // anything other than the empty code keeps the detector from falling
        assign pair_busy[i]  = in_t[i] | in_f[i];
        assign pair_bad[i]   = in_t[i] & in_f[i];
    end

    assign any_illegal = |pair_bad;

endmodule

// File: rtl/dr_celem.sv
module dr_celem #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_v,
    input  logic [WIDTH-1:0] keep_v,
    output logic             out_q
);

    logic out_d;

    always_comb begin
        out_d = out_q;
        if (&rise_v) begin
            out_d = 1'b1;
        end else if (~|keep_v) begin
            out_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

endmodule

// File: rtl/dr_stage_ctrl.sv
module dr_stage_ctrl #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] in_t,
    input  logic [NBITS-1:0] in_f,
    input  logic             dn_ack,
    output logic             up_ack,
    output logic             cd_req,
    output logic             stage_en,
    output logic             stage_sleep,
    output logic             rail_err
);

    import dr_pkg::*;

    logic [NBITS-1:0] pair_valid;
    logic [NBITS-1:0] pair_busy;
    logic             any_illegal;
    logic             ri_q;
    ctrl_t            ctl_d;
    ctrl_t            ctl_q;

    dr_rail_decode #(.NBITS(NBITS)) u_decode (
        .in_t        (in_t),
        .in_f        (in_f),
        .pair_valid  (pair_valid),
        .pair_busy   (pair_busy),
        .any_illegal (any_illegal)
    );

    // completion detector: per-pair OR into one NBITS-input C-element
    dr_celem #(.WIDTH(NBITS)) u_cd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_v (pair_valid),
        .keep_v (pair_busy),
        .out_q  (ri_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        // enhanced C* element: set by Ri and Ain, cleared by not-Ri and not-Ain
        if (ri_q && dn_ack) begin
            ctl_d.slp = 1'b1;
        end else if (!ri_q && !dn_ack) begin
            ctl_d.slp = 1'b0;
        end
        // upstream acknowledge: rises with the request, falls only once released
        if (ri_q) begin
            ctl_d.ack = 1'b1;
        end else if (!ctl_q.slp) begin
            ctl_d.ack = 1'b0;
        end
        ctl_d.err = any_illegal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTRL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cd_req      = ri_q;
    assign up_ack      = ctl_q.ack;
    assign stage_sleep = ctl_q.slp;
    assign stage_en    = ri_q & ~ctl_q.slp;
    assign rail_err    = ctl_q.err;

endmodule

// File: rtl/dr_stage_ctrl_chk.sv
module dr_stage_ctrl_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBITS-1:0] in_t,
    input logic [NBITS-1:0] in_f,
    input logic             dn_ack,
    input logic             up_ack,
    input logic             cd_req,
    input logic             stage_en,
    input logic             stage_sleep,
    input logic             rail_err
);

    p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_req) |-> $past(&(in_t ^ in_f)));

    p_req_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_req) |-> $past(~|(in_t | in_f)));

    p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rail_err |-> $past(|(in_t & in_f)));

    p_en_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en |-> (cd_req && !stage_sleep));

    p_sleep_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_sleep) |-> ($past(cd_req) && $past(dn_ack)));

    p_sleep_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_sleep) |-> (!$past(cd_req) && !$past(dn_ack)));

    p_ack_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_ack) |-> (!$past(cd_req) && !$past(stage_sleep)));

    p_hold_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_sleep && cd_req) |=> (stage_sleep || !$past(cd_req) || !cd_req || stage_sleep));

    p_ack_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> $past(cd_req));

endmodule

bind dr_stage_ctrl dr_stage_ctrl_chk #(.NBITS(NBITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_t        (in_t),
    .in_f        (in_f),
    .dn_ack      (dn_ack),
    .up_ack      (up_ack),
    .cd_req      (cd_req),
    .stage_en    (stage_en),
    .stage_sleep (stage_sleep),
    .rail_err    (rail_err)
);

// File: tb/dr_stage_ctrl_tb.sv
module dr_stage_ctrl_tb;

    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] in_t = '0;
    logic [NB-1:0] in_f = '0;
    logic          dn_ack = 1'b0;
    logic          up_ack, cd_req, stage_en, stage_sleep, rail_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int handshakes = 0;

    // bench cycle model
    logic m_ri = 1'b0, m_slp = 1'b0, m_ack = 1'b0, m_err = 1'b0;

    always #10 clk = ~clk;

    dr_stage_ctrl #(.NBITS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .dn_ack(dn_ack),
        .up_ack(up_ack), .cd_req(cd_req), .stage_en(stage_en),
        .stage_sleep(stage_sleep), .rail_err(rail_err)
    );

    function automatic logic all_valid(logic [NB-1:0] t, logic [NB-1:0] f);
        return &(t ^ f);
    endfunction

    function automatic logic all_empty(logic [NB-1:0] t, logic [NB-1:0] f);
        return ~|(t | f);
    endfunction

    task automatic chk(logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b cycle=%0d", what, act, exp, cycles);
        end
    endtask

    // one clock: model update on the edge from stable inputs, compare after it
    task automatic step();
        logic n_ri, n_slp, n_ack;
        @(posedge clk);
        cycles++;
        if (!rst_n) begin
            m_ri = 0; m_slp = 0; m_ack = 0; m_err = 0;
        end else begin
            n_ri  = all_valid(in_t, in_f) ? 1'b1 : (all_empty(in_t, in_f) ? 1'b0 : m_ri);
            n_slp = (m_ri && dn_ack) ? 1'b1 : ((!m_ri && !dn_ack) ? 1'b0 : m_slp);
            n_ack = m_ri ? 1'b1 : (!m_slp ? 1'b0 : m_ack);
            m_err = |(in_t & in_f);
            m_ri = n_ri; m_slp = n_slp; m_ack = n_ack;
        end
        @(negedge clk);
        chk(cd_req,      m_ri,             "R2/R3 cd_req");
        chk(rail_err,    m_err,            "R4 rail_err");
        chk(stage_en,    m_ri && !m_slp,   "R5/R9 stage_en");
        chk(stage_sleep, m_slp,            "R6/R7 stage_sleep");
        chk(up_ack,      m_ack,            "R8 up_ack");
    endtask

    task automatic put_word(logic [NB-1:0] w);
        in_t = w; in_f = ~w;
    endtask

    task automatic put_empty();
        in_t = '0; in_f = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int ust;
        int dst;
        int ucnt;
        int dcnt;
        void'($urandom(32'd4242));
        repeat (3) step();
        // R1: outputs low during reset
        chk(cd_req | up_ack | stage_en | stage_sleep | rail_err, 1'b0, "R1 reset");
        rst_n = 1'b1;
        step();
        chk(cd_req | up_ack | stage_en | stage_sleep | rail_err, 1'b0, "R1 after release");

        // R6 negative: downstream ack with no request does not set sleep
        dn_ack = 1'b1; step(); step();
        chk(stage_sleep, 1'b0, "R6 ack ignored when idle");
        dn_ack = 1'b0; step();

        // R4: one illegal pair among valid ones, not counted valid
        put_word(8'hA5); in_t[3] = 1'b1; in_f[3] = 1'b1;
        step();
        chk(rail_err, 1'b1, "R4 illegal flagged");
        chk(cd_req, 1'b0, "R4 illegal not valid");
        // R3: partial valid word, request must not rise
        put_word(8'hA5); in_t[6] = 1'b0; in_f[6] = 1'b0;
        step();
        chk(cd_req, 1'b0, "R3 partial word holds");
        chk(rail_err, 1'b0, "R4 flag clears");
        // R2, R5: complete word
        put_word(8'hA5); step();
        chk(cd_req, 1'b1, "R2 request up");
        chk(stage_en, 1'b1, "R5 evaluate");
        step();
        chk(up_ack, 1'b1, "R8 upstream ack");
        // R6: early sleep before empty token
        dn_ack = 1'b1; step();
        chk(stage_sleep, 1'b1, "R6 early sleep");
        chk(stage_en, 1'b0, "R5 disabled in sleep");
        // R9: downstream releases while word still present
        dn_ack = 1'b0; step(); step();
        chk(stage_sleep, 1'b1, "R9 sleep held");
        chk(stage_en, 1'b0, "R9 no re-evaluate");
        // collision: back to sleep state, then empty token and release together
        dn_ack = 1'b1; step();
        put_empty(); dn_ack = 1'b0; step();
        chk(cd_req, 1'b0, "R3 request down");
        chk(up_ack, 1'b1, "R8 ack held while sleeping");
        step();
        chk(stage_sleep, 1'b0, "R7 sleep released");
        step();
        chk(up_ack, 1'b0, "R8 ack down");

        // random four-phase traffic
        ust = 0; dst = 0; ucnt = 0; dcnt = 0;
        for (int k = 0; k < 4000; k++) begin
            case (ust)
                0: if (!up_ack) begin
                       if (ucnt == 0) begin
                           put_word(NB'($urandom));
                           if ($urandom % 3 == 0) begin
                               int b = $urandom % NB;
                               in_t[b] = 1'b0; in_f[b] = 1'b0;
                               ust = 3;
                           end else ust = 1;
                           ucnt = $urandom % 4;
                       end else ucnt--;
                   end
                3: begin put_word(NB'($urandom)); ust = 1; end
                1: if (up_ack) begin
                       if (ucnt == 0) begin
                           in_t = in_t & NB'($urandom);
                           in_f = in_f & NB'($urandom);
                           ust = 2;
                       end else ucnt--;
                   end
                default: begin
                    put_empty(); ust = 0; ucnt = $urandom % 4; handshakes++;
                end
            endcase
            case (dst)
                0: if (stage_en) begin dcnt = $urandom % 5; dst = 1; end
                1: if (dcnt == 0) begin dn_ack = 1'b1; dst = 2; end else dcnt--;
                2: if (!cd_req) begin dcnt = $urandom % 5; dst = 3; end
                default: if (dcnt == 0) begin dn_ack = 1'b0; dst = 0; end else dcnt--;
            endcase
            step();
        end
        chk(handshakes > 100, 1'b1, "R8 four-phase progress");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule